// File: doc/BRIEF.md
# Write-Through Snooping Data Cache

This block is a private data cache for one processor on a shared broadcast bus. Peer caches and other agents sit on the same bus, and the cache keeps its contents coherent with them by invalidation. Every processor store goes through to memory as a single-word bus write. A hit also updates the local copy. A store that misses does not allocate a line.

Read misses stall the processor while the whole 16-byte line is fetched. The fetch is four word beats in ascending order. The requested word is returned in the cycle after the last beat. The cache watches a snoop input that carries every bus write together with the identifier of the agent that issued it. A write from another agent that matches a resident line clears that line's valid bit. Writes that carry this cache's own identifier are ignored. If a foreign write targets the line being filled, the fill still completes and the processor still gets its word, but the line is left invalid.

The controller has four states:
- **IDLE** accepts requests. A read hit answers in the same cycle. A read miss goes to **FILL**. A store goes to **WRITE**.
- **WRITE** holds the bus request until grant and acknowledge arrive together, then returns to IDLE.
- **FILL** counts four acknowledged beats and then moves to **RESP**.
- **RESP** returns the word and moves back to IDLE.

The processor must hold its request fields steady until `cpu_ready`.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `bus_req` are low, and the first read of any address misses.
- R2: A read miss issues four bus reads (`bus_we`=0) at line base + 0, 4, 8, 12, in that order. It returns the memory word at the requested address one cycle after the fourth acknowledged beat.
- R3: A read whose tag matches a valid line returns the cached word with `cpu_ready` in the same cycle and no bus request.
- R4: Every store issues exactly one bus write (`bus_we`=1) carrying `cpu_addr` and `cpu_wdata`. `cpu_ready` rises only in the cycle where `bus_gnt` and `bus_ack` are both high.
- R5: A store that hits updates the cached word. A store that misses fills nothing, so a later read of that line misses.
- R6: A snooped write from another agent whose address falls in a valid resident line invalidates it. The next read misses and returns the new memory value.
- R7: A snooped foreign write whose tag differs from the resident line at that index leaves the line valid.
- R8: A snooped write carrying this cache's own identifier (`CACHE_ID`) changes no valid bit.
- R9: A foreign snooped write to the line being filled lets the fill finish and return the new word, but leaves the line invalid.
- R10: The cache is direct-mapped with 64 lines. The index is address bits 9:4, and a miss replaces whatever line held that index.
- R11: While `bus_req` is high and not yet granted and acknowledged, `bus_req`, `bus_we` and `bus_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Request for the shared bus |
| bus_we | output | 1 | 1 = word write, 0 = read beat |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_gnt | input | 1 | Arbiter grant |
| bus_ack | input | 1 | Beat or write completed this cycle |
| bus_rdata | input | 32 | Read beat data |
| snoop_valid | input | 1 | A write is on the bus this cycle |
| snoop_id | input | 2 | Identifier of the agent writing |
| snoop_addr | input | 32 | Address of the snooped write |

## Verification
Most internal faults in this block surface as a data miscompare or a wrong bus beat count on the next processor access to the affected line. The bench compares against its own memory model and counts read beats to tell a hit from a miss.

A valid bit that is wrongly kept shows up as stale data one access later. A valid bit that is wrongly cleared shows up as four unexpected read beats on the next access. A broken beat counter or a broken request hold shows up at the bus in the very cycle after an acknowledged or stalled beat.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_FILL,
        ST_RESP
    } cstate_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int LINES = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             sn_valid,
    input  logic [IDX_W-1:0] sn_idx,
    input  logic [TAG_W-1:0] sn_tag,
    input  logic             fill_start,
    input  logic             fill_end,
    input  logic             fill_keep
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

    always_ff @(posedge clk) begin
        if (fill_start) begin
            tag_q[lk_idx] <= lk_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (fill_start) begin
                valid_q[lk_idx] <= 1'b0;
            end
            if (sn_valid && valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag)) begin
                valid_q[sn_idx] <= 1'b0;
            end
            if (fill_end && fill_keep) begin
                valid_q[lk_idx] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
    parameter int LINES  = 64,
    parameter int WPL    = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = LINES * WPL;
    logic [DATA_W-1:0] word_q [DEPTH];

    assign rd_data = word_q[{idx, rd_word}];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{idx, wr_word}] <= wr_data;
        end
    end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WPL    = 4,
    parameter int BYTE_W = 2,
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    input  logic              lk_hit,
    input  logic              sn_on_line,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              fill_start,
    output logic              fill_end,
    output logic              fill_keep,
    output logic              dw_en,
    output logic [WSEL_W-1:0] dw_word,
    output logic [DATA_W-1:0] dw_data
);
    localparam int OFF_W = BYTE_W + WSEL_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WPL - 1);

    cstate_e           st, st_nx;
    logic [WSEL_W-1:0] beat;
    logic              kill;
    logic              xfer;

    assign xfer = bus_gnt && bus_ack;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_FILL) begin
            beat <= '0;
            kill <= 1'b0;
        end else begin
            if (xfer) begin
                beat <= beat + 1'b1;
            end
            if (sn_on_line) begin
                kill <= 1'b1;
            end
        end
    end

    always_comb begin
        st_nx      = st;
        cpu_ready  = 1'b0;
        bus_req    = 1'b0;
        bus_we     = 1'b0;
        bus_addr   = cpu_addr;
        bus_wdata  = cpu_wdata;
        fill_start = 1'b0;
        fill_end   = 1'b0;
        fill_keep  = 1'b0;
        dw_en      = 1'b0;
        dw_word    = cpu_addr[BYTE_W +: WSEL_W];
        dw_data    = cpu_wdata;
        unique case (st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        dw_en = lk_hit;
                        st_nx = ST_WRITE;
                    end else if (lk_hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        fill_start = 1'b1;
                        st_nx      = ST_FILL;
                    end
                end
            end
            ST_WRITE: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
                if (xfer) begin
                    cpu_ready = 1'b1;
                    st_nx     = ST_IDLE;
                end
            end
            ST_FILL: begin
                bus_req  = 1'b1;
                bus_addr = {cpu_addr[ADDR_W-1:OFF_W], beat, {BYTE_W{1'b0}}};
                dw_word  = beat;
                dw_data  = bus_rdata;
                if (xfer) begin
                    dw_en = 1'b1;
                    if (beat == LAST_BEAT) begin
                        fill_end  = 1'b1;
                        fill_keep = !kill && !sn_on_line;
                        st_nx     = ST_RESP;
                    end
                end
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                st_nx     = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LINES    = 64,
    parameter int WPL      = 4,
    parameter int ID_W     = 2,
    parameter int CACHE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snoop_valid,
    input  logic [ID_W-1:0]   snoop_id,
    input  logic [ADDR_W-1:0] snoop_addr
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(WPL);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    logic              sn_other, sn_on_line, lk_hit;
    logic              fill_start, fill_end, fill_keep;
    logic              dw_en;
    logic [WSEL_W-1:0] dw_word;
    logic [DATA_W-1:0] dw_data;
    logic              unused_snoop_low;

    assign sn_other   = snoop_valid && (snoop_id != ID_W'(CACHE_ID));
    assign sn_on_line = sn_other &&
                        (snoop_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]);
    assign unused_snoop_low = ^snoop_addr[OFF_W-1:0];

    wtc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (cpu_addr[OFF_W +: IDX_W]),
        .lk_tag     (cpu_addr[ADDR_W-1 -: TAG_W]),
        .lk_hit     (lk_hit),
        .sn_valid   (sn_other),
        .sn_idx     (snoop_addr[OFF_W +: IDX_W]),
        .sn_tag     (snoop_addr[ADDR_W-1 -: TAG_W]),
        .fill_start (fill_start),
        .fill_end   (fill_end),
        .fill_keep  (fill_keep)
    );

    wtc_data_store #(.LINES(LINES), .WPL(WPL), .DATA_W(DATA_W),
                     .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
        .clk     (clk),
        .wr_en   (dw_en),
        .idx     (cpu_addr[OFF_W +: IDX_W]),
        .wr_word (dw_word),
        .wr_data (dw_data),
        .rd_word (cpu_addr[BYTE_W +: WSEL_W]),
        .rd_data (cpu_rdata)
    );

    wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WPL(WPL),
               .BYTE_W(BYTE_W), .WSEL_W(WSEL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .lk_hit     (lk_hit),
        .sn_on_line (sn_on_line),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_gnt    (bus_gnt),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .fill_start (fill_start),
        .fill_end   (fill_end),
        .fill_keep  (fill_keep),
        .dw_en      (dw_en),
        .dw_word    (dw_word),
        .dw_data    (dw_data)
    );
endmodule

// File: rtl/wt_snoop_cache_chk.sv
module wt_snoop_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 2,
    parameter int WSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_gnt,
    input logic              bus_ack
);
    assert_store_done_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_ready && cpu_we |-> bus_gnt && bus_ack && bus_we);

    assert_store_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> bus_addr == cpu_addr && bus_wdata == cpu_wdata);

    assert_hit_quiet_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && !cpu_we |-> !bus_req);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !(bus_gnt && bus_ack) |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    assert_beat_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && bus_gnt && bus_ack &&
        bus_addr[BYTE_W +: WSEL_W] != {WSEL_W{1'b1}}
        |=> bus_req && !bus_we &&
            bus_addr[BYTE_W +: WSEL_W] == $past(bus_addr[BYTE_W +: WSEL_W]) + WSEL_W'(1));

    assert_fill_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) && !bus_we |-> bus_addr[BYTE_W +: WSEL_W] == '0);
endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .WSEL_W(WSEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_gnt   (bus_gnt),
    .bus_ack   (bus_ack)
);

// File: tb/wt_snoop_cache_bench.sv
`timescale 1ns/1ps
module wt_snoop_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata, bus_addr, bus_wdata, bus_rdata, snoop_addr;
    logic        cpu_ready, bus_req, bus_we, bus_gnt, bus_ack, snoop_valid;
    logic [1:0]  snoop_id;

    logic        hold = 1'b0, other_wr = 1'b0;
    logic [1:0]  other_id = 2'd1;
    logic [31:0] other_addr = '0, other_data = '0;
    logic [31:0] mem [1024];
    logic [31:0] beat_addr [4];
    int          rd_beats;
    int          vectors = 0, miscompares = 0, cycles = 0;

    // {store, expect_miss, addr, wdata}; index = addr[9:4], tag = addr[31:10]
    localparam logic [65:0] VEC [10] = '{
        {1'b0, 1'b1, 32'h0000_0104, 32'h0},
        {1'b0, 1'b0, 32'h0000_0108, 32'h0},
        {1'b1, 1'b0, 32'h0000_0104, 32'h1111_AAAA},
        {1'b0, 1'b0, 32'h0000_0104, 32'h0},
        {1'b1, 1'b0, 32'h0000_0204, 32'h2222_BBBB},
        {1'b0, 1'b1, 32'h0000_0204, 32'h0},
        {1'b0, 1'b1, 32'h0000_0504, 32'h0},
        {1'b0, 1'b1, 32'h0000_0104, 32'h0},
        {1'b0, 1'b0, 32'h0000_010C, 32'h0},
        {1'b0, 1'b0, 32'h0000_020C, 32'h0}
    };

    always #2.5 clk = ~clk;

    // environment: arbiter, memory, snoop broadcast
    assign bus_gnt     = bus_req && !(hold || other_wr);
    assign bus_ack     = bus_gnt;
    assign bus_rdata   = mem[bus_addr[11:2]];
    assign snoop_valid = other_wr || (bus_gnt && bus_we);
    assign snoop_id    = other_wr ? other_id : 2'd0;
    assign snoop_addr  = other_wr ? other_addr : bus_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 32'hC0DE_0000 | i;
            rd_beats <= 0;
        end else begin
            if (bus_gnt && bus_we) mem[bus_addr[11:2]] <= bus_wdata;
            if (other_wr) mem[other_addr[11:2]] <= other_data;
            if (bus_gnt && !bus_we) begin
                beat_addr[rd_beats[1:0]] <= bus_addr;
                rd_beats <= rd_beats + 1;
            end
        end
    end

    wt_snoop_cache u_wt_snoop_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snoop_valid(snoop_valid), .snoop_id(snoop_id), .snoop_addr(snoop_addr)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            vectors++;
            miscompares++;
            $display("FAIL R11 watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic start_op(input bit we, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    endtask

    task automatic finish_op(output logic [31:0] rd);
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1 cpu_req = 1'b0;
    endtask

    task automatic run_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        start_op(we, a, d);
        finish_op(rd);
    endtask

    task automatic other_write(input logic [1:0] id, input logic [31:0] a,
                               input logic [31:0] d);
        @(negedge clk);
        other_wr = 1'b1; other_id = id; other_addr = a; other_data = d;
        @(negedge clk);
        other_wr = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        int          b0;
        repeat (3) @(posedge clk);
        #1;
        check(cpu_ready == 1'b0, "R1 ready in reset", {31'b0, cpu_ready}, 32'h0);
        check(bus_req == 1'b0, "R1 bus_req in reset", {31'b0, bus_req}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: a line that was never touched misses
        b0 = rd_beats;
        run_op(1'b0, 32'h0000_0F34, 32'h0, rd);
        check(rd_beats - b0 == 4, "R1 first read misses", rd_beats - b0, 4);
        check(rd == mem[32'hF34 >> 2], "R1 fill data", rd, mem[32'hF34 >> 2]);

        for (int v = 0; v < 10; v++) begin
            logic [65:0] e;
            e = VEC[v];
            b0 = rd_beats;
            run_op(e[65], e[63:32], e[31:0], rd);
            if (!e[65]) begin
                check(rd == mem[e[43:34]], e[64] ? "R2 miss data" : "R3 hit data",
                      rd, mem[e[43:34]]);
                check(rd_beats - b0 == (e[64] ? 4 : 0), e[64] ? "R2 beats" : "R3 no beats",
                      rd_beats - b0, e[64] ? 4 : 0);
                if (e[64]) begin
                    for (int k = 0; k < 4; k++)
                        check(beat_addr[k] == {e[63:36], k[1:0], 2'b00}, "R2 beat order",
                              beat_addr[k], {e[63:36], k[1:0], 2'b00});
                end
            end else begin
                check(mem[e[43:34]] == e[31:0], "R4 store reached memory",
                      mem[e[43:34]], e[31:0]);
                check(rd_beats == b0, "R5 store fetches nothing", rd_beats - b0, 0);
            end
        end

        // R10: 0x504 was evicted by 0x104 (same index 0x10)
        b0 = rd_beats;
        run_op(1'b0, 32'h0000_0504, 32'h0, rd);
        check(rd_beats - b0 == 4, "R10 conflict eviction", rd_beats - b0, 4);

        // R4/R11: store stalled by a busy bus
        hold = 1'b1;
        start_op(1'b1, 32'h0000_0108, 32'h4444_CCCC);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            #1;
            check(cpu_ready == 1'b0, "R4 stall until grant", {31'b0, cpu_ready}, 32'h0);
            check(bus_req && bus_we && bus_addr == 32'h108, "R11 request held",
                  bus_addr, 32'h108);
        end
        check(mem[32'h108 >> 2] != 32'h4444_CCCC, "R4 no early write",
              mem[32'h108 >> 2], 32'hC0DE_0042);
        hold = 1'b0;
        finish_op(rd);
        check(mem[32'h108 >> 2] == 32'h4444_CCCC, "R4 write after grant",
              mem[32'h108 >> 2], 32'h4444_CCCC);

        // R6: foreign write invalidates a resident line
        run_op(1'b0, 32'h0000_0300, 32'h0, rd);
        other_write(2'd1, 32'h0000_0304, 32'h6666_0304);
        b0 = rd_beats;
        run_op(1'b0, 32'h0000_0304, 32'h0, rd);
        check(rd == 32'h6666_0304, "R6 fresh data after invalidate", rd, 32'h6666_0304);
        check(rd_beats - b0 == 4, "R6 refetch", rd_beats - b0, 4);

        // R7: foreign write, same index, other tag
        other_write(2'd1, 32'h0000_0704, 32'h7777_0704);
        b0 = rd_beats;
        run_op(1'b0, 32'h0000_0300, 32'h0, rd);
        check(rd_beats == b0, "R7 line kept", rd_beats - b0, 0);
        check(rd == mem[32'h300 >> 2], "R7 data", rd, mem[32'h300 >> 2]);

        // R8: write tagged with own identifier is ignored
        other_write(2'd0, 32'h0000_0300, mem[32'h300 >> 2]);
        b0 = rd_beats;
        run_op(1'b0, 32'h0000_0308, 32'h0, rd);
        check(rd_beats == b0, "R8 own snoop ignored", rd_beats - b0, 0);

        // R9: foreign write to the line being filled
        hold = 1'b1;
        b0 = rd_beats;
        start_op(1'b0, 32'h0000_0800, 32'h0);
        repeat (2) @(negedge clk);
        other_write(2'd1, 32'h0000_0800, 32'hDEAD_0800);
        hold = 1'b0;
        finish_op(rd);
        check(rd == 32'hDEAD_0800, "R9 fill returns word", rd, 32'hDEAD_0800);
        check(rd_beats - b0 == 4, "R9 fill completes", rd_beats - b0, 4);
        b0 = rd_beats;
        run_op(1'b0, 32'h0000_0800, 32'h0, rd);
        check(rd_beats - b0 == 4, "R9 line left invalid", rd_beats - b0, 4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule